// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called side A and side B. Each side has a storage register of its own. In any cycle the block can do one of three things: carry the live value of one bus across to the other, drive a value captured earlier onto a bus, or stay isolated and drive neither bus. Each bus pin is split into an input value, an output value and an output enable. A pad ring or an upper level of the design makes the real tri-state connection. This keeps the block synthesizable.

The two registers have separate capture clocks. Each register samples its own bus on every rising edge of its clock, whatever state the drive controls are in. A store can therefore run while the block is isolated, or while the other bus is being driven. A parameter selects the output polarity: data passes through unchanged, or every bit is complemented. The data paths are plain pins with no valid/ready handshake. There is no back-pressure: a value is taken on a clock edge and is presented for as long as the controls select it. The drive controls and the output data are purely combinational.

Top module: `regxcvr`

## Requirements
- R1: An active-low asynchronous reset clears both storage registers to all zeros. With the true polarity, the stored value driven after reset is 8'h00. With the inverting polarity it is 8'hFF.
- R2: The side-A register loads `a_in` on every rising edge of `clk_ab`, for any value of `oe_n`, `dir` and the selects.
- R3: The side-B register loads `b_in` on every rising edge of `clk_ba`, for any value of `oe_n`, `dir` and the selects.
- R4: While `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R5: While `oe_n` is 0, `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0, and `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0.
- R6: While A is driven, `sel_ba` = 0 puts the live `b_in` on `a_out`, and `sel_ba` = 1 puts the side-B register on `a_out`.
- R7: While B is driven, `sel_ab` = 0 puts the live `a_in` on `b_out`, and `sel_ab` = 1 puts the side-A register on `b_out`.
- R8: With `INVERT` = 1 the driven value is the bitwise complement of the selected source. With `INVERT` = 0 it is the source unchanged.
- R9: `a_oe` and `b_oe` are never 1 at the same time.
- R10: When a register is clocked while its stored value is being driven, the new value appears on the output right after that edge, with no extra cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_ab | input | 1 | Capture clock of the side-A register |
| clk_ba | input | 1 | Capture clock of the side-B register |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 0: drive side A, 1: drive side B |
| sel_ab | input | 1 | Source toward B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source toward A: 0 live B, 1 stored B |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Value to drive on bus A, meaningful while a_oe is 1 |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Value to drive on bus B, meaningful while b_oe is 1 |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The enables and the live-path data settle in the same cycle as their inputs. A register load shows on a stored-path output straight after the rising edge that caused it. The bench sets every input at a falling edge of its 50 MHz reference, so the capture clocks rise only at the next rising edge. It reads all outputs at the following falling edge, half a period after any capture, and compares them against a reference model that is updated just after that rising edge. The true-polarity and inverting instances see the same stimulus and are checked together.

// File: rtl/regxcvr_pkg.sv
package regxcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  localparam int SIDE_A = 0;
  localparam int SIDE_B = 1;
  localparam int NUM_SIDES = 2;

endpackage

// File: rtl/regxcvr_store.sv
module regxcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/regxcvr_route.sv
module regxcvr_route
  import regxcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  src_e         src,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);

  logic [W-1:0] picked;

  always_comb begin
    picked = (src == SRC_STORED) ? stored : live;
  end

  generate
    if (INVERT) begin : g_inv
      assign y = ~picked;
    end else begin : g_true
      assign y = picked;
    end
  endgenerate

endmodule

// File: rtl/regxcvr_drive.sv
module regxcvr_drive (
  input  logic oe_n,
  input  logic dir,
  output logic a_oe,
  output logic b_oe
);

  always_comb begin
    a_oe = 1'b0;
    b_oe = 1'b0;
    if (!oe_n) begin
      if (dir) b_oe = 1'b1;
      else     a_oe = 1'b1;
    end
  end

endmodule

// File: rtl/regxcvr.sv
module regxcvr
  import regxcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         rst_n,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  // Each index is the side whose bus feeds the register and the route.
  logic [W-1:0] side_in    [NUM_SIDES];
  logic [W-1:0] side_q     [NUM_SIDES];
  logic [W-1:0] side_y     [NUM_SIDES];
  logic         side_clk   [NUM_SIDES];
  src_e         side_src   [NUM_SIDES];
  logic [W-1:0] store_a;
  logic [W-1:0] store_b;

  assign side_in[SIDE_A]  = a_in;
  assign side_in[SIDE_B]  = b_in;
  assign side_clk[SIDE_A] = clk_ab;
  assign side_clk[SIDE_B] = clk_ba;
  assign side_src[SIDE_A] = src_e'(sel_ab);
  assign side_src[SIDE_B] = src_e'(sel_ba);

  generate
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      regxcvr_store #(.W(W)) u_store (
        .clk   (side_clk[s]),
        .rst_n (rst_n),
        .d     (side_in[s]),
        .q     (side_q[s])
      );

      regxcvr_route #(.W(W), .INVERT(INVERT)) u_route (
        .src    (side_src[s]),
        .live   (side_in[s]),
        .stored (side_q[s]),
        .y      (side_y[s])
      );
    end
  endgenerate

  regxcvr_drive u_drive (
    .oe_n (oe_n),
    .dir  (dir),
    .a_oe (a_oe),
    .b_oe (b_oe)
  );

  assign store_a = side_q[SIDE_A];
  assign store_b = side_q[SIDE_B];
  assign b_out   = side_y[SIDE_A];
  assign a_out   = side_y[SIDE_B];

endmodule

// File: rtl/regxcvr_chk.sv
module regxcvr_chk #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input logic         rst_n,
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_oe,
  input logic         b_oe,
  input logic [W-1:0] store_a,
  input logic [W-1:0] store_b
);

  logic [W-1:0] mask;
  assign mask = INVERT ? {W{1'b1}} : {W{1'b0}};

  always_comb begin
    // R9
    one_driver_chk: assert (!(a_oe && b_oe));
    // R4
    isolate_chk: assert (!oe_n || (!a_oe && !b_oe));
    // R5
    dir_pick_chk: assert (oe_n || (a_oe == !dir && b_oe == dir));
    // R6
    toward_a_chk: assert (!a_oe ||
      (a_out == ((sel_ba ? store_b : b_in) ^ mask)));
    // R7
    toward_b_chk: assert (!b_oe ||
      (b_out == ((sel_ab ? store_a : a_in) ^ mask)));
  end

  // R2
  load_a_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    1'b1 |=> (store_a == $past(a_in)));

  // R3
  load_b_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    1'b1 |=> (store_b == $past(b_in)));

endmodule

bind regxcvr regxcvr_chk #(.W(W), .INVERT(INVERT)) u_chk (
  .rst_n   (rst_n),
  .clk_ab  (clk_ab),
  .clk_ba  (clk_ba),
  .oe_n    (oe_n),
  .dir     (dir),
  .sel_ab  (sel_ab),
  .sel_ba  (sel_ba),
  .a_in    (a_in),
  .b_in    (b_in),
  .a_out   (a_out),
  .b_out   (b_out),
  .a_oe    (a_oe),
  .b_oe    (b_oe),
  .store_a (store_a),
  .store_b (store_b)
);

// File: tb/regxcvr_test.sv
`timescale 1ns/1ps
module regxcvr_test;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_ab = 1'b0, en_ba = 1'b0;
  logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic clk_ab, clk_ba;
  logic [W-1:0] a_out0, b_out0, a_out1, b_out1;
  logic a_oe0, b_oe0, a_oe1, b_oe1;

  logic [W-1:0] ma = '0, mb = '0;
  logic last_eab = 1'b0, last_eba = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign clk_ab = clk & en_ab;
  assign clk_ba = clk & en_ba;

  regxcvr #(.W(W), .INVERT(1'b0)) uut (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out0), .a_oe(a_oe0),
    .b_in(b_in), .b_out(b_out0), .b_oe(b_oe0));

  regxcvr #(.W(W), .INVERT(1'b1)) uut_inv (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out1), .a_oe(a_oe1),
    .b_in(b_in), .b_out(b_out1), .b_oe(b_oe1));

  function automatic logic [W-1:0] pol(input logic inv, input logic [W-1:0] x);
    return inv ? ~x : x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic verify_one(input logic inv, input logic [W-1:0] ao, input logic aoe,
                            input logic [W-1:0] bo, input logic boe);
    logic exp_aoe, exp_boe;
    string ta, tb;
    exp_aoe = !oe_n && !dir;
    exp_boe = !oe_n && dir;
    chk(oe_n ? "R4 a_oe" : "R5 a_oe", 32'(aoe), 32'(exp_aoe));
    chk(oe_n ? "R4 b_oe" : "R5 b_oe", 32'(boe), 32'(exp_boe));
    chk("R9 both", 32'(aoe & boe), 32'd0);
    if (exp_boe) begin
      tb = sel_ab ? (last_eab ? "R10 stored->B" : "R2 stored->B") : "R7 live->B";
      if (inv) tb = {"R8 ", tb};
      chk(tb, 32'(bo), 32'(pol(inv, sel_ab ? ma : a_in)));
    end
    if (exp_aoe) begin
      ta = sel_ba ? (last_eba ? "R10 stored->A" : "R3 stored->A") : "R6 live->A";
      if (inv) ta = {"R8 ", ta};
      chk(ta, 32'(ao), 32'(pol(inv, sel_ba ? mb : b_in)));
    end
  endtask

  task automatic verify_all();
    verify_one(1'b0, a_out0, a_oe0, b_out0, b_oe0);
    verify_one(1'b1, a_out1, a_oe1, b_out1, b_oe1);
  endtask

  // Called at a falling edge: drive, pass one rising edge, check at next falling edge.
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic on,
                      input logic d, input logic sab, input logic sba,
                      input logic eab, input logic eba);
    a_in = a; b_in = b; oe_n = on; dir = d; sel_ab = sab; sel_ba = sba;
    en_ab = eab; en_ba = eba;
    @(posedge clk);
    #1;
    if (eab) ma = a;
    if (eba) mb = b;
    last_eab = eab; last_eba = eba;
    @(negedge clk);
    en_ab = 1'b0; en_ba = 1'b0;
    verify_all();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: stored values after reset, driven toward B then toward A
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
    chk("R1 regA->B true", 32'(b_out0), 32'h00);
    chk("R1 regA->B inv", 32'(b_out1), 32'hFF);
    dir = 1'b0; sel_ba = 1'b1; #1;
    chk("R1 regB->A true", 32'(a_out0), 32'h00);
    chk("R1 regB->A inv", 32'(a_out1), 32'hFF);
    @(negedge clk);

    // R2/R3 store while isolated, then show stored values
    step(8'hA5, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    step(8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 isolated store", 32'(b_out0), 32'hA5);
    step(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 isolated store", 32'(a_out0), 32'h3C);
    // R10 clock the driven register
    step(8'h5A, 8'h11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R10 same-edge B", 32'(b_out0), 32'h5A);
    step(8'h22, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R10 same-edge A", 32'(a_out0), 32'hC3);
    // R6/R7 live paths, extreme values
    step(8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      step(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule